// File: doc/BRIEF.md
# Shared Interrupt Distributor with Affinity and One-of-N Routing

This block collects a parameterised set of shared interrupt lines (32 by default) and hands each of several processors (4 by default) the single best interrupt it should take next. Every line has an enable, a priority, a group assignment, a trigger type and a routing entry. All of these are programmed through a flat register port that writes in one cycle and reads combinationally. Rising edges or levels on the inputs become pending state. A processor takes its presented interrupt by pulsing its acknowledge bit.

Routing works in one of two ways. A line can be pinned to one processor by an affinity value. It can also be handed to any processor that takes part in distributing its group, with the choice rotating between processors. Each processor can opt out of that shared delivery for each group. Global per-group enables stop a whole group at once. A security mode hides Group 0 configuration from non-secure register accesses.

Address layout: `addr[11:8]` selects the register kind and `addr[7:0]` the index. For per-bit kinds the index is the 32-interrupt word, for per-interrupt kinds it is the interrupt ID, and for opt-out it is the processor. The kinds are: 0 control, 1 set-enable, 2 clear-enable, 3 group, 4 group modifier, 5 trigger, 6 priority, 7 affinity, 8 routing mode and 9 opt-out.

Top module: `irq_dist`

## Requirements
- R1: A write to kind 1 sets the enable of each interrupt whose data bit is 1, and a write to kind 2 clears the enable of each such interrupt. Zero bits leave enables unchanged. Reads of kind 1 and kind 2 both return the current enables.
- R2: Priority (kind 6) keeps only its upper PRIO_BITS bits (5 by default) of the 8-bit field in bits [7:0]. The lower bits read as zero. The value 0 is the most urgent, and among equal priorities the lowest interrupt ID is presented.
- R3: Trigger bit 1 (kind 5) means edge. A rising input sets pending, and acknowledging the presented ID clears it. Trigger bit 0 means level: pending follows the input, and acknowledging does not clear it.
- R4: With routing mode 0 (kind 8, bit 0 = 0), an interrupt goes only to processor p. Processor p has affinity value p in bits [7:0] and zero in bits [31:8] of kind 7. A value that matches no processor delivers to nobody.
- R5: With routing mode 1, an interrupt goes to the first eligible processor, searching upward from a rotation pointer and wrapping. The pointer is 0 after reset. When processor p acknowledges a mode-1 interrupt, the pointer moves to p+1 modulo the processor count.
- R6: Opt-out (kind 9, index p) bit 0 covers Group 0, bit 1 Secure Group 1 and bit 2 Non-secure Group 1. A processor whose bit is set for an interrupt's group is not eligible for mode-1 delivery of that interrupt.
- R7: Group is taken from the group bit g (kind 3) and the modifier bit m (kind 4). When g=0 the group is Group 0. When g=1 and m=1 with two security states, the group is Secure Group 1. In every other case it is Non-secure Group 1. Control bits [2:0] enable these three groups globally, and an interrupt of a disabled group is presented to nobody.
- R8: Control bit 3 selects single security state. Once it is set, only reset clears it. While it is clear, an access with `reg_ns_i`=1 reads zero from, and cannot change, any configuration of an interrupt whose group bit is 0. Such an access sees and writes only control bit 2.
- R9: A change of pending state reaches the presented outputs one clock after it is registered. The outputs hold a valid flag, an ID and an 8-bit priority for each processor.
- R10: After reset all enables, configuration, pending state and outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_IRQ | Interrupt input lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_ns_i | input | 1 | Access is non-secure |
| reg_addr_i | input | 12 | Register kind and index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data |
| ack_i | input | NUM_PE | Per-processor acknowledge pulse |
| irq_valid_o | output | NUM_PE | Processor has an interrupt presented |
| irq_id_o | output | NUM_PE*ID_W | Presented interrupt ID per processor |
| irq_prio_o | output | NUM_PE*8 | Presented priority per processor |

## Verification
A wrong rotation pointer sends the next shared interrupt to the wrong processor. That shows up on the valid flags within two cycles of the next pending edge. Corrupted pending or enable state shows as a wrong or missing presented ID two cycles after the input change or acknowledge that exposes it. A security filtering fault shows at once on the combinational read data, or as configuration that a later secure read finds changed. The random phase compares every processor's output against a model after each input change and each acknowledge, so any divergence is caught at the first such step.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  typedef enum logic [3:0] {
    K_CTRL   = 4'd0,
    K_SETEN  = 4'd1,
    K_CLREN  = 4'd2,
    K_GROUP  = 4'd3,
    K_GMOD   = 4'd4,
    K_TRIG   = 4'd5,
    K_PRIO   = 4'd6,
    K_AFF    = 4'd7,
    K_RMODE  = 4'd8,
    K_OPTOUT = 4'd9
  } reg_kind_e;

  localparam logic [1:0] GRP_0   = 2'd0;
  localparam logic [1:0] GRP_1S  = 2'd1;
  localparam logic [1:0] GRP_1NS = 2'd2;

  function automatic logic [1:0] grp_class(logic g, logic m, logic single);
    if (!g) return GRP_0;
    if (m && !single) return GRP_1S;
    return GRP_1NS;
  endfunction
endpackage

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ   = 32,
  parameter int NUM_PE    = 4,
  parameter int PRIO_BITS = 5
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic                               ns_i,
  input  logic [11:0]                        addr_i,
  input  logic [31:0]                        wdata_i,
  output logic [31:0]                        rdata_o,
  output logic [NUM_IRQ-1:0]                 en_o,
  output logic [NUM_IRQ-1:0]                 grp_o,
  output logic [NUM_IRQ-1:0]                 mod_o,
  output logic [NUM_IRQ-1:0]                 trig_o,
  output logic [NUM_IRQ-1:0]                 rmode_o,
  output logic [NUM_IRQ-1:0][PRIO_BITS-1:0]  prio_o,
  output logic [NUM_IRQ-1:0][31:0]           aff_o,
  output logic [NUM_PE-1:0][2:0]             optout_o,
  output logic [2:0]                         grp_en_o,
  output logic                               single_o
);
  logic [3:0] kind;
  logic [7:0] idx;
  logic [NUM_IRQ-1:0] ok, hit_irq, hit_word;

  logic [NUM_IRQ-1:0]                en_q, grp_q, mod_q, trig_q, rmode_q;
  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio_q;
  logic [NUM_IRQ-1:0][31:0]          aff_q;
  logic [NUM_PE-1:0][2:0]            optout_q;
  logic [2:0]                        grp_en_q;
  logic                              single_q;

  assign kind = addr_i[11:8];
  assign idx  = addr_i[7:0];

  // Non-secure view hides Group 0 lines while two security states are active
  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      ok[i]       = !(ns_i && !single_q && !grp_q[i]);
      hit_irq[i]  = (idx == 8'(i));
      hit_word[i] = (idx == 8'(i / 32));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      grp_q    <= '0;
      mod_q    <= '0;
      trig_q   <= '0;
      rmode_q  <= '0;
      prio_q   <= '0;
      aff_q    <= '0;
      optout_q <= '0;
      grp_en_q <= '0;
      single_q <= 1'b0;
    end else if (we_i) begin
      if (kind == K_CTRL && idx == 8'd0) begin
        if (ns_i && !single_q) begin
          grp_en_q[2] <= wdata_i[2];
        end else begin
          grp_en_q <= wdata_i[2:0];
          if (wdata_i[3]) single_q <= 1'b1;
        end
      end
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (ok[i] && hit_word[i]) begin
          case (kind)
            K_SETEN: if (wdata_i[i % 32]) en_q[i] <= 1'b1;
            K_CLREN: if (wdata_i[i % 32]) en_q[i] <= 1'b0;
            K_GROUP: grp_q[i]  <= wdata_i[i % 32];
            K_GMOD:  mod_q[i]  <= wdata_i[i % 32];
            K_TRIG:  trig_q[i] <= wdata_i[i % 32];
            default: ;
          endcase
        end
        if (ok[i] && hit_irq[i]) begin
          case (kind)
            K_PRIO:  prio_q[i]  <= wdata_i[7 -: PRIO_BITS];
            K_AFF:   aff_q[i]   <= wdata_i;
            K_RMODE: rmode_q[i] <= wdata_i[0];
            default: ;
          endcase
        end
      end
      for (int p = 0; p < NUM_PE; p++) begin
        if (kind == K_OPTOUT && idx == 8'(p)) optout_q[p] <= wdata_i[2:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (kind)
      K_CTRL: begin
        if (idx == 8'd0) begin
          if (ns_i && !single_q) rdata_o[2] = grp_en_q[2];
          else rdata_o[3:0] = {single_q, grp_en_q};
        end
      end
      K_SETEN, K_CLREN, K_GROUP, K_GMOD, K_TRIG: begin
        for (int i = 0; i < NUM_IRQ; i++) begin
          if (ok[i] && hit_word[i]) begin
            case (kind)
              K_GROUP: rdata_o[i % 32] = grp_q[i];
              K_GMOD:  rdata_o[i % 32] = mod_q[i];
              K_TRIG:  rdata_o[i % 32] = trig_q[i];
              default: rdata_o[i % 32] = en_q[i];
            endcase
          end
        end
      end
      K_PRIO, K_AFF, K_RMODE: begin
        for (int i = 0; i < NUM_IRQ; i++) begin
          if (ok[i] && hit_irq[i]) begin
            case (kind)
              K_PRIO:  rdata_o[7 -: PRIO_BITS] = prio_q[i];
              K_AFF:   rdata_o = aff_q[i];
              default: rdata_o[0] = rmode_q[i];
            endcase
          end
        end
      end
      K_OPTOUT: begin
        for (int p = 0; p < NUM_PE; p++) begin
          if (idx == 8'(p)) rdata_o[2:0] = optout_q[p];
        end
      end
      default: ;
    endcase
  end

  assign en_o     = en_q;
  assign grp_o    = grp_q;
  assign mod_o    = mod_q;
  assign trig_o   = trig_q;
  assign rmode_o  = rmode_q;
  assign prio_o   = prio_q;
  assign aff_o    = aff_q;
  assign optout_o = optout_q;
  assign grp_en_o = grp_en_q;
  assign single_o = single_q;

  // R8
  ds_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_q |=> single_q);

  // R8
  ns_g0_prio_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ns_i && !single_q && kind == K_PRIO && |(hit_irq & ~grp_q))
    |=> $stable(prio_q));

  generate
    if (PRIO_BITS < 8) begin : g_lsb_chk
      // R2
      prio_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kind == K_PRIO) |-> (rdata_o[7-PRIO_BITS:0] == '0));
    end
  endgenerate
endmodule

// File: rtl/irq_dist_pending.sv
module irq_dist_pending #(
  parameter int NUM_IRQ = 32,
  parameter int NUM_PE  = 4,
  parameter int ID_W    = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_IRQ-1:0]            irq_i,
  input  logic [NUM_IRQ-1:0]            trig_i,
  input  logic [NUM_PE-1:0]             ack_i,
  input  logic [NUM_PE-1:0]             ack_valid_i,
  input  logic [NUM_PE-1:0][ID_W-1:0]   ack_id_i,
  output logic [NUM_IRQ-1:0]            pend_o
);
  logic [NUM_IRQ-1:0] irq_q, pend_q, pend_d, rise, clr;

  always_comb begin
    clr = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      for (int p = 0; p < NUM_PE; p++) begin
        if (ack_i[p] && ack_valid_i[p] && ack_id_i[p] == ID_W'(i)) clr[i] = 1'b1;
      end
    end
  end

  assign rise   = irq_i & ~irq_q;
  // a new edge in the acknowledge cycle wins over the clear
  assign pend_d = (trig_i & (rise | (pend_q & ~clr))) | (~trig_i & irq_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R3
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(pend_q & trig_i & ~clr) & trig_i) & ~pend_q) == '0));

  // R3
  level_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~$past(trig_i) & (pend_q ^ $past(irq_i))) == '0));
endmodule

// File: rtl/irq_dist_route.sv
module irq_dist_route #(
  parameter int NUM_IRQ = 32,
  parameter int NUM_PE  = 4,
  parameter int ID_W    = 5
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_IRQ-1:0]               rmode_i,
  input  logic [NUM_IRQ-1:0][31:0]         aff_i,
  input  logic [NUM_IRQ-1:0][1:0]          cls_i,
  input  logic [NUM_PE-1:0][2:0]           optout_i,
  input  logic [NUM_PE-1:0]                ack_i,
  input  logic [NUM_PE-1:0]                ack_valid_i,
  input  logic [NUM_PE-1:0][ID_W-1:0]      ack_id_i,
  output logic [NUM_IRQ-1:0][NUM_PE-1:0]   tgt_o
);
  localparam int PE_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1;

  logic [PE_W-1:0]   rr_q, rr_d;
  logic              ack_hit;
  logic [NUM_PE-1:0] ack_shared;

  always_comb begin
    for (int p = 0; p < NUM_PE; p++) begin
      ack_shared[p] = 1'b0;
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (ack_id_i[p] == ID_W'(i) && rmode_i[i]) ack_shared[p] = 1'b1;
      end
    end
    ack_hit = 1'b0;
    rr_d    = rr_q;
    for (int p = 0; p < NUM_PE; p++) begin
      if (ack_i[p] && ack_valid_i[p] && ack_shared[p]) begin
        ack_hit = 1'b1;
        rr_d    = (p == NUM_PE - 1) ? '0 : PE_W'(p + 1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else         rr_q <= rr_d;
  end

  always_comb begin
    int  pp;
    logic found;
    pp    = 0;
    found = 1'b0;
    tgt_o = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      found = 1'b0;
      if (rmode_i[i]) begin
        for (int k = 0; k < NUM_PE; k++) begin
          pp = int'(rr_q) + k;
          if (pp >= NUM_PE) pp = pp - NUM_PE;
          if (!found && !optout_i[pp][cls_i[i]]) begin
            tgt_o[i][pp] = 1'b1;
            found        = 1'b1;
          end
        end
      end else begin
        for (int p = 0; p < NUM_PE; p++) tgt_o[i][p] = (aff_i[i] == 32'(p));
      end
    end
  end

  // R5
  rr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_hit |=> $stable(rr_q));
endmodule

// File: rtl/irq_dist_arb.sv
module irq_dist_arb #(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 5,
  parameter int ID_W      = 5
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_IRQ-1:0]                cand_i,
  input  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio_i,
  output logic                              valid_o,
  output logic [ID_W-1:0]                   id_o,
  output logic [PRIO_BITS-1:0]              prio_o
);
  logic                 found;
  logic [ID_W-1:0]      best_id;
  logic [PRIO_BITS-1:0] best_prio;

  // ascending scan with strict compare keeps the lowest ID on ties
  always_comb begin
    found     = 1'b0;
    best_id   = '0;
    best_prio = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand_i[i] && (!found || prio_i[i] < best_prio)) begin
        found     = 1'b1;
        best_id   = ID_W'(i);
        best_prio = prio_i[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      id_o    <= '0;
      prio_o  <= '0;
    end else begin
      valid_o <= found;
      id_o    <= found ? best_id : '0;
      prio_o  <= found ? best_prio : '0;
    end
  end

  // R9
  arb_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(|cand_i));
endmodule

// File: rtl/irq_dist.sv
module irq_dist
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ   = 32,
  parameter int NUM_PE    = 4,
  parameter int PRIO_BITS = 5,
  localparam int ID_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_IRQ-1:0]      irq_i,
  input  logic                    reg_we_i,
  input  logic                    reg_ns_i,
  input  logic [11:0]             reg_addr_i,
  input  logic [31:0]             reg_wdata_i,
  output logic [31:0]             reg_rdata_o,
  input  logic [NUM_PE-1:0]       ack_i,
  output logic [NUM_PE-1:0]       irq_valid_o,
  output logic [NUM_PE*ID_W-1:0]  irq_id_o,
  output logic [NUM_PE*8-1:0]     irq_prio_o
);
  logic [NUM_IRQ-1:0]                en, grp, gmod, trig, rmode, pend, live;
  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio;
  logic [NUM_IRQ-1:0][31:0]          aff;
  logic [NUM_IRQ-1:0][1:0]           cls;
  logic [NUM_IRQ-1:0][NUM_PE-1:0]    tgt;
  logic [NUM_PE-1:0][2:0]            optout;
  logic [2:0]                        grp_en;
  logic                              single;
  logic [NUM_PE-1:0]                 arb_valid;
  logic [NUM_PE-1:0][ID_W-1:0]       arb_id;
  logic [NUM_PE-1:0][PRIO_BITS-1:0]  arb_prio;

  irq_dist_regs #(.NUM_IRQ(NUM_IRQ), .NUM_PE(NUM_PE), .PRIO_BITS(PRIO_BITS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .ns_i     (reg_ns_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .en_o     (en),
    .grp_o    (grp),
    .mod_o    (gmod),
    .trig_o   (trig),
    .rmode_o  (rmode),
    .prio_o   (prio),
    .aff_o    (aff),
    .optout_o (optout),
    .grp_en_o (grp_en),
    .single_o (single)
  );

  irq_dist_pending #(.NUM_IRQ(NUM_IRQ), .NUM_PE(NUM_PE), .ID_W(ID_W)) u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_i       (irq_i),
    .trig_i      (trig),
    .ack_i       (ack_i),
    .ack_valid_i (arb_valid),
    .ack_id_i    (arb_id),
    .pend_o      (pend)
  );

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      cls[i]  = grp_class(grp[i], gmod[i], single);
      live[i] = pend[i] && en[i] && grp_en[cls[i]];
    end
  end

  irq_dist_route #(.NUM_IRQ(NUM_IRQ), .NUM_PE(NUM_PE), .ID_W(ID_W)) u_route (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rmode_i     (rmode),
    .aff_i       (aff),
    .cls_i       (cls),
    .optout_i    (optout),
    .ack_i       (ack_i),
    .ack_valid_i (arb_valid),
    .ack_id_i    (arb_id),
    .tgt_o       (tgt)
  );

  generate
    for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
      logic [NUM_IRQ-1:0] cand;
      always_comb begin
        for (int i = 0; i < NUM_IRQ; i++) cand[i] = live[i] && tgt[i][p];
      end

      irq_dist_arb #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W)) u_arb (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cand_i  (cand),
        .prio_i  (prio),
        .valid_o (arb_valid[p]),
        .id_o    (arb_id[p]),
        .prio_o  (arb_prio[p])
      );

      assign irq_id_o[p*ID_W +: ID_W] = arb_id[p];
      assign irq_prio_o[p*8 +: 8]     = 8'(arb_prio[p]) << (8 - PRIO_BITS);
    end
  endgenerate

  assign irq_valid_o = arb_valid;
endmodule

// File: tb/tb_irq_dist.sv
module tb_irq_dist;
  localparam int N = 32, P = 4, PB = 5, IDW = 5;
  localparam int KC = 0, KSE = 1, KCE = 2, KG = 3, KM = 4, KT = 5, KP = 6, KA = 7, KR = 8, KO = 9;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic we = 1'b0, ns = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [P-1:0] ack = '0, valid;
  logic [P*IDW-1:0] ids;
  logic [P*8-1:0] prios;

  irq_dist #(.NUM_IRQ(N), .NUM_PE(P), .PRIO_BITS(PB)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq_in), .reg_we_i(we), .reg_ns_i(ns),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ack_i(ack),
    .irq_valid_o(valid), .irq_id_o(ids), .irq_prio_o(prios)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  bit m_en[N], m_grp[N], m_mod[N], m_trig[N], m_rmode[N], m_ep[N];
  int m_prio[N];
  int unsigned m_aff[N];
  bit [2:0] m_opt[P];
  bit [2:0] m_gen;
  bit m_single;
  int m_rr;

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(int k, int idx, logic [31:0] d, bit n);
    @(negedge clk);
    we = 1'b1; addr = {4'(k), 8'(idx)}; wdata = d; ns = n;
    @(negedge clk);
    we = 1'b0; ns = 1'b0;
  endtask

  task automatic rd(int k, int idx, bit n, output logic [31:0] v);
    @(negedge clk);
    addr = {4'(k), 8'(idx)}; ns = n;
    #1 v = rdata;
    ns = 1'b0;
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      m_en[i] = 0; m_grp[i] = 0; m_mod[i] = 0; m_trig[i] = 0; m_rmode[i] = 0;
      m_ep[i] = 0; m_prio[i] = 0; m_aff[i] = 0;
    end
    for (int p = 0; p < P; p++) m_opt[p] = '0;
    m_gen = '0; m_single = 0; m_rr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; irq_in = '0; ack = '0;
    waitc(2);
    rst_ni = 1'b1;
    model_clear();
  endtask

  function automatic int cls(int i);
    if (!m_grp[i]) return 0;
    if (m_mod[i] && !m_single) return 1;
    return 2;
  endfunction

  function automatic bit tgt(int i, int p);
    if (m_rmode[i]) begin
      for (int k = 0; k < P; k++) begin
        int q = (m_rr + k) % P;
        if (!m_opt[q][cls(i)]) return q == p;
      end
      return 0;
    end
    return m_aff[i] == p;
  endfunction

  task automatic pick(int p, output bit v, output int id, output int pr);
    v = 0; id = 0; pr = 255;
    for (int i = 0; i < N; i++) begin
      bit pend = m_trig[i] ? m_ep[i] : irq_in[i];
      if (pend && m_en[i] && m_gen[cls(i)] && tgt(i, p) && (!v || m_prio[i] < pr)) begin
        v = 1; id = i; pr = m_prio[i];
      end
    end
  endtask

  task automatic check_outputs(string tag);
    for (int p = 0; p < P; p++) begin
      bit v; int id, pr;
      pick(p, v, id, pr);
      chk({tag, " valid"}, int'(valid[p]), int'(v));
      if (v) begin
        chk({tag, " id"}, int'(ids[p*IDW +: IDW]), id);
        chk({tag, " prio"}, int'(prios[p*8 +: 8]), pr);
      end
    end
  endtask

  task automatic push_all();
    logic [31:0] e, g, m, t;
    for (int i = 0; i < N; i++) begin
      e[i] = m_en[i]; g[i] = m_grp[i]; m[i] = m_mod[i]; t[i] = m_trig[i];
    end
    wr(KG, 0, g, 0); wr(KM, 0, m, 0); wr(KT, 0, t, 0);
    for (int i = 0; i < N; i++) begin
      wr(KP, i, 32'(m_prio[i]), 0);
      wr(KA, i, m_aff[i], 0);
      wr(KR, i, 32'(m_rmode[i]), 0);
    end
    for (int p = 0; p < P; p++) wr(KO, p, 32'(m_opt[p]), 0);
    wr(KSE, 0, e, 0); wr(KCE, 0, ~e, 0);
    wr(KC, 0, {28'd0, m_single, m_gen}, 0);
    waitc(3);
  endtask

  task automatic pulse(int i);
    @(negedge clk); irq_in[i] = 1'b1; if (m_trig[i]) m_ep[i] = 1;
    @(negedge clk); irq_in[i] = 1'b0;
    waitc(3);
  endtask

  task automatic do_ack(int p);
    bit v; int id, pr;
    pick(p, v, id, pr);
    @(negedge clk); ack = 4'(1 << p);
    @(negedge clk); ack = '0;
    if (v) begin
      if (m_trig[id]) m_ep[id] = 0;
      if (m_rmode[id]) m_rr = (p + 1) % P;
    end
    waitc(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int unsigned seed;
    model_clear();
    waitc(3);
    rst_ni = 1'b1;
    waitc(1);

    // R10 reset state
    chk("R10 valid", int'(valid), 0);
    rd(KC, 0, 0, v); chk("R10 ctrl", v, 0);
    rd(KSE, 0, 0, v); chk("R10 enables", v, 0);

    // R1 set/clear enables
    wr(KSE, 0, 32'hF0, 0); wr(KCE, 0, 32'h30, 0); wr(KSE, 0, 32'h0, 0);
    rd(KSE, 0, 0, v); chk("R1 set-enable read", v, 32'hC0);
    rd(KCE, 0, 0, v); chk("R1 clear-enable read", v, 32'hC0);

    // R2 priority width
    wr(KP, 3, 32'hFF, 0); rd(KP, 3, 0, v); chk("R2 prio ff", v, 32'hF8);
    wr(KP, 4, 32'h13, 0); rd(KP, 4, 0, v); chk("R2 prio 13", v, 32'h10);

    // R8 non-secure filtering of Group 0
    rd(KP, 3, 1, v); chk("R8 ns read g0 prio", v, 0);
    wr(KP, 3, 32'h0, 1); rd(KP, 3, 0, v); chk("R8 ns write g0 prio ignored", v, 32'hF8);
    wr(KCE, 0, 32'h80, 1); rd(KSE, 0, 0, v); chk("R8 ns clear g0 ignored", v, 32'hC0);
    wr(KC, 0, 32'h7, 0); rd(KC, 0, 1, v); chk("R8 ns ctrl view", v, 32'h4);
    wr(KC, 0, 32'h0, 1); rd(KC, 0, 0, v); chk("R8 ns ctrl write", v, 32'h3);
    wr(KC, 0, 32'hF, 0); wr(KC, 0, 32'h7, 0);
    rd(KC, 0, 0, v); chk("R8 single sticky", v, 32'hF);
    rd(KP, 3, 1, v); chk("R8 single ns access", v, 32'hF8);

    // R5 / R6 one-of-N rotation and opt-out
    do_reset();
    m_en[0] = 1; m_grp[0] = 1; m_trig[0] = 1; m_prio[0] = 8'h10; m_rmode[0] = 1;
    m_gen = 3'b100;
    push_all();
    pulse(0); check_outputs("R5 first");
    chk("R5 pe0 gets it", int'(valid), 1);
    do_ack(0); check_outputs("R5 after ack");
    pulse(0); check_outputs("R5 rotated");
    chk("R5 pe1 gets it", int'(valid), 2);
    wr(KO, 2, 32'h4, 0); m_opt[2] = 3'b100;
    do_ack(1);
    pulse(0); check_outputs("R6 opt-out skip");
    chk("R6 pe3 gets it", int'(valid), 8);
    do_ack(3);

    // R4 affinity routing
    m_en[7] = 1; m_grp[7] = 1; m_trig[7] = 1; m_prio[7] = 8'h08; m_aff[7] = 2;
    m_en[8] = 1; m_grp[8] = 1; m_trig[8] = 1; m_prio[8] = 8'h08; m_aff[8] = 32'h100;
    m_en[9] = 1; m_grp[9] = 1; m_trig[9] = 1; m_prio[9] = 8'h18; m_aff[9] = 1;
    m_en[10] = 1; m_grp[10] = 1; m_trig[10] = 1; m_prio[10] = 8'h18; m_aff[10] = 1;
    m_en[12] = 1; m_grp[12] = 1; m_prio[12] = 8'h00; m_aff[12] = 0;
    push_all();
    pulse(7); pulse(8); check_outputs("R4 affinity");
    chk("R4 only pe2", int'(valid), 4);

    // R2 tie goes to lowest ID
    pulse(10); pulse(9); check_outputs("R2 tie");
    chk("R2 tie id", int'(ids[1*IDW +: IDW]), 9);
    do_ack(1); check_outputs("R2 next after ack");
    chk("R2 second id", int'(ids[1*IDW +: IDW]), 10);

    // R7 global group disable
    wr(KC, 0, 32'h3, 0); m_gen = 3'b011; waitc(3);
    check_outputs("R7 group off");
    chk("R7 nothing valid", int'(valid), 0);
    wr(KC, 0, 32'h4, 0); m_gen = 3'b100; waitc(3);
    check_outputs("R7 group on");

    // R9 latency, R3 level behaviour
    do_ack(2); do_ack(1);
    @(negedge clk); irq_in[12] = 1'b1;
    @(negedge clk); chk("R9 not yet visible", int'(valid[0]), 0);
    @(negedge clk); chk("R9 visible after two edges", int'(valid[0]), 1);
    check_outputs("R3 level high");
    do_ack(0); check_outputs("R3 level survives ack");
    chk("R3 level id", int'(ids[0 +: IDW]), 12);
    @(negedge clk); irq_in[12] = 1'b0; waitc(3);
    check_outputs("R3 level low");

    // random phase
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    do_reset();
    for (int i = 0; i < N; i++) m_trig[i] = 1'($urandom);
    for (int it = 0; it < 400; it++) begin
      if (it % 100 == 0) begin
        for (int i = 0; i < N; i++) begin
          m_en[i] = ($urandom % 4) != 0;
          m_grp[i] = 1'($urandom); m_mod[i] = 1'($urandom);
          m_prio[i] = int'($urandom % 4) << 3;
          m_aff[i] = ($urandom % 8 == 0) ? 32'h100 : ($urandom % 5);
          m_rmode[i] = 1'($urandom);
        end
        for (int p = 0; p < P; p++) m_opt[p] = 3'($urandom) & 3'($urandom);
        m_gen = ($urandom % 3 == 0) ? 3'($urandom) : 3'b111;
        push_all();
      end
      begin
        logic [N-1:0] nx = irq_in ^ (N'($urandom) & N'($urandom) & N'($urandom));
        for (int i = 0; i < N; i++) if (m_trig[i] && nx[i] && !irq_in[i]) m_ep[i] = 1;
        @(negedge clk); irq_in = nx;
      end
      waitc(3);
      check_outputs("R4 R5 R6 R7 random");
      if ($urandom % 2 == 0) begin
        do_ack(int'($urandom % P));
        check_outputs("R3 R5 random ack");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule